// File: doc/BRIEF.md
# SPI Flash Command Acceptance Controller

This block is the command front end of a serial flash model. It watches the serial clock, chip select and serial data input, all sampled on the system clock. While chip select is low it counts rising serial clock edges and takes the first eight bits as the instruction. When chip select returns high it sorts the instruction into one of three groups: instructions that change state, instructions that only read, and unknown codes. For an instruction that changes state it then decides whether to execute it, drop it or ignore it.

An executed instruction produces a one-cycle commit strobe together with its opcode. A dropped one produces a one-cycle reject strobe. Program, erase and status-write instructions start an internal busy period. A programmable system-clock count, with one count for each operation, stands in for the real program and erase time.

While busy, the block filters incoming instructions. Status polls pass without effect. A suspend instruction can freeze a program or erase, and a resume instruction lets it continue. The memory array, the data-out path and multi-line I/O are not part of this block.

Top module: `spi_cmd_accept`

## Requirements
- R1: State-changing instructions are 06 (set write latch), 04 (clear write latch), 02 (program), 20 (small erase), D8 (sector erase), C7 (full erase), 01 (status write), 75 (suspend) and 7A (resume). One of these is acted on only if chip select rises when the count of serial clock rising edges since chip select fell is a nonzero multiple of eight. At any other count it gives a reject pulse and changes no state.
- R2: commit and reject are single-cycle pulses. They are never high together. Each appears in the cycle after the first clock edge that samples cs_n high. commit_op holds the opcode that was committed.
- R3: None of the following produces a commit, a reject or a change of state: a transaction of fewer than eight bits, an unknown opcode, or a status read (05) or flag read (70) of any length.
- R4: Opcode 06 sets the write latch (wel) and opcode 04 clears it. Neither needs the latch to be set first.
- R5: Opcodes 02, 20, D8, C7 and 01 are rejected if wel is 0. When one commits, it clears wel and raises busy in the same cycle as the commit pulse.
- R6: busy stays high for exactly the configured number of clocks for its operation, not counting cycles spent suspended. wip is high exactly when busy is high and suspended is low.
- R7: While busy and not suspended, every state-changing instruction except suspend is ignored, with no commit and no reject. Reads during this time do not change the length of the busy period.
- R8: Suspend (75) sent while a program (02) or erase (20, D8) is running sets suspended and freezes the busy count. While a full erase (C7) or a status write (01) is running, suspend is ignored.
- R9: Resume (7A) sent while suspended commits, clears suspended and lets the count continue from where it stopped. At any other time it is ignored.
- R10: While suspended, 06 and 04 are accepted. Program, erase and status-write opcodes are ignored.
- R11: After reset, commit, reject, busy, suspended, wip and wel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled on clk |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, MSB first |
| commit | output | 1 | One-cycle pulse for an executed instruction |
| commit_op | output | 8 | Opcode of the last committed instruction |
| reject | output | 1 | One-cycle pulse for a dropped instruction |
| busy | output | 1 | Internal operation in progress |
| suspended | output | 1 | Internal operation paused |
| wip | output | 1 | Write in progress: busy and not suspended |
| wel | output | 1 | Write enable latch |

## Verification
Assertions check on every cycle the properties that hold at all times:
- strobes never overlap;
- a strobe appears only after chip select has been seen high;
- the write latch follows each committed opcode;
- busy only rises on a commit;
- suspended implies busy, and busy cannot end while suspended;
- suspended clears only on a committed resume;
- nothing but suspend commits during an active busy period.

The bench's scenarios are needed for the rest:
- whether a given bit count commits or rejects;
- that a read leaves the busy length unchanged;
- that suspend is ignored during a full erase;
- the exact length of each busy period.

// File: rtl/spi_cmd_pkg.sv
// Package: opcode constants, instruction classes and classification helpers
// shared by the decision logic. Assumes 8-bit opcodes sent MSB first.
package spi_cmd_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_SET_WEL  = 8'h06;
    localparam logic [OP_W-1:0] OPC_CLR_WEL  = 8'h04;
    localparam logic [OP_W-1:0] OPC_PROG     = 8'h02;
    localparam logic [OP_W-1:0] OPC_ERASE_SM = 8'h20;
    localparam logic [OP_W-1:0] OPC_ERASE_SC = 8'hD8;
    localparam logic [OP_W-1:0] OPC_ERASE_AL = 8'hC7;
    localparam logic [OP_W-1:0] OPC_STAT_WR  = 8'h01;
    localparam logic [OP_W-1:0] OPC_SUSPEND  = 8'h75;
    localparam logic [OP_W-1:0] OPC_RESUME   = 8'h7A;
    localparam logic [OP_W-1:0] OPC_STAT_RD  = 8'h05;
    localparam logic [OP_W-1:0] OPC_FLAG_RD  = 8'h70;

    typedef enum logic [3:0] {
        CL_NONE, CL_SET_WEL, CL_CLR_WEL, CL_PROG, CL_ERASE_SM, CL_ERASE_SC,
        CL_ERASE_AL, CL_STAT_WR, CL_SUSPEND, CL_RESUME, CL_READ
    } op_class_e;

    // Map an opcode to its class; unknown codes map to CL_NONE.
    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        case (op)
            OPC_SET_WEL:              return CL_SET_WEL;
            OPC_CLR_WEL:              return CL_CLR_WEL;
            OPC_PROG:                 return CL_PROG;
            OPC_ERASE_SM:             return CL_ERASE_SM;
            OPC_ERASE_SC:             return CL_ERASE_SC;
            OPC_ERASE_AL:             return CL_ERASE_AL;
            OPC_STAT_WR:              return CL_STAT_WR;
            OPC_SUSPEND:              return CL_SUSPEND;
            OPC_RESUME:               return CL_RESUME;
            OPC_STAT_RD, OPC_FLAG_RD: return CL_READ;
            default:                  return CL_NONE;
        endcase
    endfunction

    // Operations that may be paused by a suspend instruction.
    function automatic logic can_pause(input op_class_e c);
        return (c == CL_PROG) || (c == CL_ERASE_SM) || (c == CL_ERASE_SC);
    endfunction

endpackage

// File: rtl/spi_bit_capture.sv
// Module: spi_bit_capture
// Samples the serial clock, chip select and data on the system clock.
// Counts serial clock rising edges modulo the opcode width while chip
// select is low and latches the first opcode-width bits as the opcode.
// Assumes sclk is at most a quarter of clk so each level is seen twice.
module spi_bit_capture
    import spi_cmd_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         sdi,
    output logic         cs_rise,
    output logic         byte_seen,
    output logic         aligned,
    output logic [W-1:0] opcode
);
    localparam int CW = $clog2(W);

    logic          sclk_q;
    logic          cs_q;
    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  shreg;
    logic          sclk_edge;
    logic          cs_fall;

    assign sclk_edge = sclk & ~sclk_q & ~cs_n;
    assign cs_fall   = ~cs_n & cs_q;
    assign cs_rise   = cs_n & ~cs_q;
    assign aligned   = (bit_cnt == '0);

    // Edge history of the serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Bit counter, shift register and opcode capture for one transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            byte_seen <= 1'b0;
            shreg     <= '0;
            opcode    <= '0;
        end else if (cs_fall) begin
            bit_cnt   <= '0;
            byte_seen <= 1'b0;
        end else if (sclk_edge) begin
            shreg <= {shreg[W-3:0], sdi};
            if (bit_cnt == CW'(W - 1)) begin
                bit_cnt   <= '0;
                byte_seen <= 1'b1;
                if (!byte_seen) opcode <= {shreg, sdi};
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_busy_timer.sv
// Module: spi_busy_timer
// Counts down a loaded duration while not held. Busy is high from the
// load cycle until the count expires. Assumes load values of at least 1.
module spi_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             hold,
    output logic             busy,
    output logic             ending
);
    logic [CNT_W-1:0] cnt;

    assign ending = busy & ~hold & (cnt == CNT_W'(1));

    // Load, count down, and clear busy on the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (ending) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && !hold) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spi_cmd_decide.sv
// Module: spi_cmd_decide
// At each chip-select rise that follows a complete opcode, decides whether
// the instruction commits, is rejected or is ignored. Owns the write latch,
// the suspend flag and the class of the running operation. Assumes busy
// and ending come from spi_busy_timer.
module spi_cmd_decide
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PROG_CYC = 1000,
    parameter int SM_CYC   = 2000,
    parameter int SC_CYC   = 4000,
    parameter int AL_CYC   = 8000,
    parameter int STAT_CYC = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise,
    input  logic             byte_seen,
    input  logic             aligned,
    input  logic [OP_W-1:0]  opcode,
    input  logic             busy,
    input  logic             ending,
    output logic             commit,
    output logic [OP_W-1:0]  commit_op,
    output logic             reject,
    output logic             wel,
    output logic             suspended,
    output logic             start,
    output logic [CNT_W-1:0] load
);
    op_class_e cls;
    op_class_e kind;
    op_class_e nxt_kind;
    logic      do_commit;
    logic      do_reject;
    logic      nxt_wel;
    logic      nxt_susp;
    logic      active;

    // Duration of each long operation in system clocks.
    function automatic logic [CNT_W-1:0] dur(input op_class_e c);
        case (c)
            CL_PROG:     return CNT_W'(PROG_CYC);
            CL_ERASE_SM: return CNT_W'(SM_CYC);
            CL_ERASE_SC: return CNT_W'(SC_CYC);
            CL_ERASE_AL: return CNT_W'(AL_CYC);
            default:     return CNT_W'(STAT_CYC);
        endcase
    endfunction

    assign cls    = classify(opcode);
    assign active = busy & ~suspended;

    // Acceptance decision and next state for the latch, suspend and kind.
    always_comb begin
        do_commit = 1'b0;
        do_reject = 1'b0;
        start     = 1'b0;
        load      = '0;
        nxt_wel   = wel;
        nxt_susp  = suspended;
        nxt_kind  = kind;
        if (cs_rise && byte_seen) begin
            case (cls)
                CL_SET_WEL, CL_CLR_WEL: begin
                    if (!aligned) do_reject = 1'b1;
                    else if (!active) begin
                        do_commit = 1'b1;
                        nxt_wel   = (cls == CL_SET_WEL);
                    end
                end
                CL_PROG, CL_ERASE_SM, CL_ERASE_SC, CL_ERASE_AL, CL_STAT_WR: begin
                    if (!aligned) do_reject = 1'b1;
                    else if (!busy) begin
                        if (!wel) do_reject = 1'b1;
                        else begin
                            do_commit = 1'b1;
                            nxt_wel   = 1'b0;
                            start     = 1'b1;
                            load      = dur(cls);
                            nxt_kind  = cls;
                        end
                    end
                end
                CL_SUSPEND: begin
                    if (!aligned) do_reject = 1'b1;
                    else if (active && !ending && can_pause(kind)) begin
                        do_commit = 1'b1;
                        nxt_susp  = 1'b1;
                    end
                end
                CL_RESUME: begin
                    if (!aligned) do_reject = 1'b1;
                    else if (suspended) begin
                        do_commit = 1'b1;
                        nxt_susp  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Register strobes and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit    <= 1'b0;
            reject    <= 1'b0;
            commit_op <= '0;
            wel       <= 1'b0;
            suspended <= 1'b0;
            kind      <= CL_NONE;
        end else begin
            commit    <= do_commit;
            reject    <= do_reject;
            if (do_commit) commit_op <= opcode;
            wel       <= nxt_wel;
            suspended <= nxt_susp;
            kind      <= nxt_kind;
        end
    end

endmodule

// File: rtl/spi_cmd_accept.sv
// Module: spi_cmd_accept (top)
// Command acceptance front end of a serial flash model: opcode capture,
// byte-boundary commit rule, write latch, busy timing and suspend/resume.
// Assumes serial inputs already in the clk domain and sclk <= clk/4.
module spi_cmd_accept
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PROG_CYC = 1000,
    parameter int SM_CYC   = 2000,
    parameter int SC_CYC   = 4000,
    parameter int AL_CYC   = 8000,
    parameter int STAT_CYC = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            sdi,
    output logic            commit,
    output logic [OP_W-1:0] commit_op,
    output logic            reject,
    output logic            busy,
    output logic            suspended,
    output logic            wip,
    output logic            wel
);
    logic             cs_rise;
    logic             byte_seen;
    logic             aligned;
    logic [OP_W-1:0]  opcode;
    logic             start;
    logic [CNT_W-1:0] load;
    logic             ending;

    spi_bit_capture #(.W(OP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .cs_rise(cs_rise), .byte_seen(byte_seen), .aligned(aligned),
        .opcode(opcode)
    );

    spi_cmd_decide #(
        .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SM_CYC(SM_CYC),
        .SC_CYC(SC_CYC), .AL_CYC(AL_CYC), .STAT_CYC(STAT_CYC)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .byte_seen(byte_seen),
        .aligned(aligned), .opcode(opcode), .busy(busy), .ending(ending),
        .commit(commit), .commit_op(commit_op), .reject(reject), .wel(wel),
        .suspended(suspended), .start(start), .load(load)
    );

    spi_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load),
        .hold(suspended), .busy(busy), .ending(ending)
    );

    assign wip = busy & ~suspended;

endmodule

// File: rtl/spi_cmd_accept_chk.sv
// Module: spi_cmd_accept_chk
// Property checker bound to spi_cmd_accept; observes its ports only.
module spi_cmd_accept_chk
    import spi_cmd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            commit,
    input logic [OP_W-1:0] commit_op,
    input logic            reject,
    input logic            busy,
    input logic            suspended,
    input logic            wel
);
    logic long_op;
    assign long_op = (commit_op == OPC_PROG) || (commit_op == OPC_ERASE_SM) ||
                     (commit_op == OPC_ERASE_SC) || (commit_op == OPC_ERASE_AL) ||
                     (commit_op == OPC_STAT_WR);

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(commit && reject)); // R1
    AST_STROBE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) (commit || reject) |-> $past(cs_n)); // R2
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) commit |=> !commit); // R2
    AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reject |=> !reject); // R2
    AST_SET_WEL: assert property (@(posedge clk) disable iff (!rst_n) (commit && commit_op == OPC_SET_WEL) |-> wel); // R4
    AST_LONG_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n) (commit && long_op) |-> (!wel && busy)); // R5
    AST_BUSY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> commit); // R6
    AST_ONLY_SUSPEND_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) (commit && $past(busy && !suspended)) |-> commit_op == OPC_SUSPEND); // R7
    AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) suspended |-> busy); // R8
    AST_FROZEN_SUSP: assert property (@(posedge clk) disable iff (!rst_n) (busy && suspended) |=> busy); // R8
    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $fell(suspended) |-> (commit && commit_op == OPC_RESUME)); // R9

endmodule

bind spi_cmd_accept spi_cmd_accept_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .commit(commit),
    .commit_op(commit_op), .reject(reject), .busy(busy),
    .suspended(suspended), .wel(wel)
);

// File: tb/spi_cmd_accept_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus scenario
// checks on counted strobes, latch state and busy-run lengths.
module spi_cmd_accept_tb;
    localparam int T_PP = 300, T_SSE = 150, T_SE = 200, T_BE = 320, T_WRSR = 120;

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
    logic commit, reject, busy, suspended, wip, wel;
    logic [7:0] commit_op;

    always #2.5 clk = ~clk;

    spi_cmd_accept #(.CNT_W(16), .PROG_CYC(T_PP), .SM_CYC(T_SSE), .SC_CYC(T_SE),
                     .AL_CYC(T_BE), .STAT_CYC(T_WRSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .commit(commit), .commit_op(commit_op), .reject(reject), .busy(busy),
        .suspended(suspended), .wip(wip), .wel(wel));

    int checks = 0, errors = 0;

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Reference model state
    int m_nbits, m_op, m_cnt, m_kind, m_cop;
    bit m_sclkq, m_csq, m_wel, m_busy, m_susp, m_commit, m_reject;

    function automatic int dur(int op);
        case (op)
            'h02: return T_PP;
            'h20: return T_SSE;
            'hD8: return T_SE;
            'hC7: return T_BE;
            default: return T_WRSR;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit rise, fall, sr, ending, al, active, osusp, st;
        int ld;
        if (!rst_n) begin
            m_nbits = 0; m_op = 0; m_cnt = 0; m_kind = 0; m_cop = 0;
            m_sclkq = 0; m_csq = 1; m_wel = 0; m_busy = 0; m_susp = 0;
            m_commit = 0; m_reject = 0;
        end else begin
            m_commit = 0; m_reject = 0; st = 0; ld = 0;
            rise = cs_n && !m_csq;
            fall = !cs_n && m_csq;
            sr = sclk && !m_sclkq && !cs_n;
            osusp = m_susp;
            ending = m_busy && !m_susp && m_cnt == 1;
            active = m_busy && !m_susp;
            if (rise && m_nbits >= 8) begin
                al = (m_nbits % 8) == 0;
                case (m_op)
                    'h06, 'h04: if (!al) m_reject = 1;
                        else if (!active) begin m_commit = 1; m_cop = m_op; m_wel = (m_op == 'h06); end
                    'h02, 'h20, 'hD8, 'hC7, 'h01: if (!al) m_reject = 1;
                        else if (!m_busy) begin
                            if (!m_wel) m_reject = 1;
                            else begin m_commit = 1; m_cop = m_op; m_wel = 0; st = 1; ld = dur(m_op); m_kind = m_op; end
                        end
                    'h75: if (!al) m_reject = 1;
                        else if (active && !ending && (m_kind == 'h02 || m_kind == 'h20 || m_kind == 'hD8)) begin
                            m_commit = 1; m_cop = m_op; m_susp = 1;
                        end
                    'h7A: if (!al) m_reject = 1;
                        else if (m_susp) begin m_commit = 1; m_cop = m_op; m_susp = 0; end
                    default: ;
                endcase
            end
            if (st) begin m_busy = 1; m_cnt = ld; end
            else if (ending) begin m_busy = 0; m_cnt = 0; end
            else if (m_busy && !osusp) m_cnt--;
            if (fall) begin m_nbits = 0; m_op = 0; end
            else if (sr) begin
                if (m_nbits < 8) m_op = ((m_op << 1) | int'(sdi)) & 255;
                m_nbits++;
            end
            m_csq = cs_n; m_sclkq = sclk;
        end
    end

    // Monitor: per-cycle comparison and strobe / busy-run bookkeeping.
    int n_commit = 0, n_reject = 0, last_op = 0, run = 0, last_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "commit", commit, m_commit);
            chk("R1", "reject", reject, m_reject);
            if (m_commit) chk("R2", "commit_op", commit_op, m_cop);
            chk("R6", "busy", busy, m_busy);
            chk("R8", "suspended", suspended, m_susp);
            chk("R6", "wip", wip, m_busy && !m_susp);
            chk("R4", "wel", wel, m_wel);
            if (commit) begin n_commit++; last_op = commit_op; end
            if (reject) n_reject++;
            if (busy) run++;
            else if (run > 0) begin last_run = run; run = 0; end
        end
    end

    task automatic xfer(input int nb, input logic [31:0] w);
        @(negedge clk) cs_n = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sdi = w[31-i]; sclk = 0;
            repeat (2) @(negedge clk);
            sclk = 1;
            repeat (2) @(negedge clk);
        end
        sclk = 0;
        repeat (2) @(negedge clk);
        cs_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    int c0, r0;
    task automatic snap(); c0 = n_commit; r0 = n_reject; endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R11", "reset commit", commit, 0);
        chk("R11", "reset reject", reject, 0);
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset suspended", suspended, 0);
        chk("R11", "reset wip", wip, 0);
        chk("R11", "reset wel", wel, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1: bit counts 7, 8, 9, 16
        snap(); xfer(7, 32'h0600_0000);
        chk("R1", "7-bit set latch commits", n_commit - c0, 0);
        chk("R1", "7-bit set latch wel", wel, 0);
        snap(); xfer(8, 32'h0600_0000);
        chk("R1", "8-bit commit", n_commit - c0, 1);
        chk("R4", "set latch op", last_op, 'h06);
        chk("R4", "wel after set", wel, 1);
        snap(); xfer(9, 32'h0400_0000);
        chk("R1", "9-bit reject", n_reject - r0, 1);
        chk("R1", "9-bit commits", n_commit - c0, 0);
        chk("R1", "wel unchanged after reject", wel, 1);
        snap(); xfer(16, 32'h0400_0000);
        chk("R1", "16-bit commit", n_commit - c0, 1);
        chk("R4", "wel after clear", wel, 0);

        // R5: program without latch
        snap(); xfer(32, 32'h0200_1000);
        chk("R5", "program without wel rejected", n_reject - r0, 1);
        chk("R5", "no busy after reject", busy, 0);

        // R3: short, unknown, reads
        snap(); xfer(8, 32'hAB00_0000); xfer(13, 32'h0500_0000);
        xfer(8, 32'h7000_0000); xfer(3, 32'h0000_0000);
        chk("R3", "ignored commits", n_commit - c0, 0);
        chk("R3", "ignored rejects", n_reject - r0, 0);

        // R7, R8, R9, R10: program with suspend / resume
        xfer(8, 32'h0600_0000);
        snap(); xfer(32, 32'h0201_2345);
        chk("R5", "program commit", n_commit - c0, 1);
        chk("R5", "program op", last_op, 'h02);
        chk("R5", "wel cleared", wel, 0);
        chk("R5", "busy set", busy, 1);
        snap(); xfer(13, 32'h0500_0000); xfer(8, 32'h0600_0000);
        chk("R7", "set latch while busy ignored", n_commit - c0, 0);
        chk("R7", "no reject while busy", n_reject - r0, 0);
        chk("R7", "wel stays 0", wel, 0);
        snap(); xfer(8, 32'h7500_0000);
        chk("R8", "suspend commits", n_commit - c0, 1);
        chk("R8", "suspended set", suspended, 1);
        chk("R6", "wip low while suspended", wip, 0);
        repeat (T_PP) @(negedge clk);
        chk("R8", "busy frozen", busy, 1);
        snap(); xfer(8, 32'h0600_0000);
        chk("R10", "set latch while suspended", n_commit - c0, 1);
        chk("R10", "wel set while suspended", wel, 1);
        snap(); xfer(32, 32'hD800_0000);
        chk("R10", "erase while suspended ignored", n_commit - c0, 0);
        chk("R10", "no reject while suspended", n_reject - r0, 0);
        snap(); xfer(8, 32'h7A00_0000);
        chk("R9", "resume commits", n_commit - c0, 1);
        chk("R9", "suspended cleared", suspended, 0);
        chk("R6", "wip after resume", wip, 1);
        wait_idle();

        // R8, R7, R6: full erase cannot be suspended, reads leave length
        snap(); xfer(8, 32'hC700_0000);
        chk("R5", "full erase commit", n_commit - c0, 1);
        snap(); xfer(8, 32'h7500_0000); xfer(8, 32'h7000_0000);
        chk("R8", "suspend ignored in full erase", n_commit - c0, 0);
        chk("R8", "not suspended", suspended, 0);
        wait_idle();
        chk("R7", "full erase busy length with polls", last_run, T_BE);

        // R1, R6: misaligned erase, then small erase length
        xfer(8, 32'h0600_0000);
        snap(); xfer(9, 32'hD800_0000);
        chk("R1", "misaligned erase rejected", n_reject - r0, 1);
        chk("R1", "no busy", busy, 0);
        chk("R1", "wel kept", wel, 1);
        snap(); xfer(32, 32'h2000_4000);
        chk("R5", "small erase commit", n_commit - c0, 1);
        wait_idle();
        chk("R6", "small erase busy length", last_run, T_SSE);

        // R5, R6: status write with trailing data byte
        xfer(8, 32'h0600_0000);
        snap(); xfer(16, 32'h0100_0000);
        chk("R5", "status write commit", n_commit - c0, 1);
        chk("R5", "status write op", last_op, 'h01);
        wait_idle();
        chk("R6", "status write busy length", last_run, T_WRSR);

        // R9: resume when not suspended
        snap(); xfer(8, 32'h7A00_0000); xfer(8, 32'h7500_0000);
        chk("R9", "resume/suspend idle ignored", n_commit - c0, 0);
        chk("R9", "no reject", n_reject - r0, 0);

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule